// File: doc/BRIEF.md
# Byte-Lane Static RAM Functional Model

This block is a clock-sampled functional model of a word-wide static RAM that has two chip enables of opposite polarity, an active-low write strobe, an active-low output enable and one active-low select per byte lane. On every rising clock edge it samples the control pins and classifies the cycle as standby, write, read or output-off. A write stores the selected byte lanes of `din` at the addressed word. A read drives the stored word onto the selected lanes of a tri-state data bus, which is modelled as a value bus `dout` and a per-bit drive-enable bus `dout_en`.

Read data appears only after an access delay. A fresh access waits `FULL_LAT` sampling edges. While a read stays open, a change that touches only the word-in-page address bits waits the shorter `PAGE_LAT`. The model is meant to stand in for an external memory in a chip-level simulation or emulation. For that reason the pins are plain levels, not a stream handshake: a device of this kind cannot apply back-pressure, so there is no ready or valid signal at the edge. The array holds `DEPTH` words. Address bits above log2(`DEPTH`) are not decoded.

Top module: `sram_bytelane`

## Requirements
- R1: The device is selected only when `cs1_n` is 0 and `cs2` is 1. In any other state, writes leave the array unchanged, and `dout_en` is all zero after the edge that samples that state.
- R2: When every bit of `lane_n` is 1, the device behaves as deselected. Writes are ignored and `dout_en` is all zero after that edge.
- R3: A selected cycle with `we_n` = 0 is a write, whatever the level of `oe_n`. `dout_en` is all zero after such an edge.
- R4: On a write, lane k (bits 8k+7 down to 8k; lane 0 is the lower byte) is stored only when `lane_n[k]` is 0. An unselected lane keeps its previous contents.
- R5: A selected cycle with `we_n` = 1 and `oe_n` = 0 is a read. Once the latency has elapsed, every bit of a selected lane has `dout_en` = 1 and carries the stored data. Every bit of an unselected lane has `dout_en` = 0 and `dout` = 0. While address and lanes are held, the output stays constant.
- R6: A selected cycle with `we_n` = 1 and `oe_n` = 1 drives nothing: `dout_en` is all zero after that edge.
- R7: A fresh read access begins on the first read edge after any non-read cycle, on a change of page (address bits above bit 3), on a change of any higher address bit, or on a change of lane selects. For a fresh access, `dout_en` stays zero until the edge that is `FULL_LAT`-1 edges after the first sampling edge. The data is driven after that edge.
- R8: During an open read with unchanged lanes, a change that affects only address bits 3..0 makes data valid `PAGE_LAT` edges after the edge that samples the new address, counting that edge. Before then `dout_en` is zero.
- R9: The stored word index is the low log2(`DEPTH`) address bits. Addresses that differ only above those bits select the same word.
- R10: While `rst_n` is 0, and immediately after its release, `dout_en` is all zero. The array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| cs1_n | input | 1 | Active-low chip enable |
| cs2 | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| lane_n | input | LANES (2) | Active-low byte-lane selects, bit 0 = lower byte |
| addr | input | ADDR_W (19) | Word address; bits 3..0 pick the word in a page |
| din | input | LANES*LANE_W (16) | Write data |
| dout | output | LANES*LANE_W (16) | Read data, zero on undriven bits |
| dout_en | output | LANES*LANE_W (16) | Per-bit drive enable of the data bus |

## Verification
On every cycle, the assertions check that the output bus is released after any standby, deselect, write or output-off cycle. They also check that each lane is driven as a whole, that undriven bits read as zero, and that a held read keeps its value. Other properties need a history of the array or of the cycle count, and only the bench scenarios can show them. These are whether the stored data is correct, whether an unselected lane survives a partial write, whether blocked writes really leave the array alone, whether high address bits alias, and the exact cycle at which full-latency and in-page reads become valid.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_WRITE   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_OFF     = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_bl_decode.sv
module sram_bl_decode
  import sram_bl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] lane_sel
);
  logic selected;

  always_comb begin
    lane_sel = ~lane_n;
    // both enables plus at least one lane are required
    selected = !cs1_n && cs2 && (|lane_sel);
    if (!selected)   mode = MODE_STANDBY;
    else if (!we_n)  mode = MODE_WRITE;   // output enable has no say here
    else if (!oe_n)  mode = MODE_READ;
    else             mode = MODE_OFF;
  end
endmodule

// File: rtl/sram_bl_array.sv
module sram_bl_array #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g]) store[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[idx];
  end
endmodule

// File: rtl/sram_bl_timer.sv
module sram_bl_timer #(
  parameter int ADDR_W    = 19,
  parameter int PAGE_BITS = 4,
  parameter int LANES     = 2,
  parameter int FULL_LAT  = 4,
  parameter int PAGE_LAT  = 2,
  localparam int CNT_W    = $clog2(FULL_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_now,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lanes,
  output logic              ready
);
  logic              prev_rd;
  logic [ADDR_W-1:0] prev_addr;
  logic [LANES-1:0]  prev_lanes;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic              same_word, same_page, keep_open;

  always_comb begin
    same_word = (prev_addr == addr);
    same_page = (prev_addr[ADDR_W-1:PAGE_BITS] == addr[ADDR_W-1:PAGE_BITS]);
    keep_open = prev_rd && (prev_lanes == lanes);
    if (keep_open && same_word)
      cnt_nx = (cnt == '0) ? '0 : cnt - CNT_W'(1);
    else if (keep_open && same_page)
      cnt_nx = CNT_W'(PAGE_LAT - 1);      // in-page word change
    else
      cnt_nx = CNT_W'(FULL_LAT - 1);      // fresh access
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rd    <= 1'b0;
      prev_addr  <= '0;
      prev_lanes <= '0;
      cnt        <= '0;
      ready      <= 1'b0;
    end else begin
      prev_rd    <= rd_now;
      prev_addr  <= addr;
      prev_lanes <= lanes;
      if (rd_now) begin
        cnt   <= cnt_nx;
        ready <= (cnt_nx == '0);
      end else begin
        cnt   <= '0;
        ready <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sram_bytelane.sv
module sram_bytelane
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DEPTH     = 1024,
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int PAGE_BITS = 4,
  parameter int FULL_LAT  = 4,
  parameter int PAGE_LAT  = 2,
  localparam int DATA_W   = LANES * LANE_W,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_en
);
  sram_mode_e        mode;
  logic [LANES-1:0]  lane_sel, lane_q;
  logic [DATA_W-1:0] rdata, data_q, lane_bits;
  logic              ready;

  sram_bl_decode #(.LANES(LANES)) u_decode (
    .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n), .oe_n(oe_n),
    .lane_n(lane_n), .mode(mode), .lane_sel(lane_sel)
  );

  sram_bl_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(mode == MODE_WRITE), .wr_lanes(lane_sel),
    .idx(addr[IDX_W-1:0]), .wdata(din), .rdata(rdata)
  );

  sram_bl_timer #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LANES(LANES),
    .FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .rd_now(mode == MODE_READ),
    .addr(addr), .lanes(lane_sel), .ready(ready)
  );

  // capture the word and lanes seen at the sampling edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      lane_q <= '0;
    end else begin
      data_q <= rdata;
      lane_q <= lane_sel;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_expand
    assign lane_bits[g*LANE_W +: LANE_W] = {LANE_W{lane_q[g]}};
  end

  assign dout_en = ready ? lane_bits : '0;
  assign dout    = data_q & dout_en;
endmodule

// File: rtl/sram_bytelane_chk.sv
module sram_bytelane_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              we_n,
  input logic              oe_n,
  input logic [LANES-1:0]  lane_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dout,
  input logic [DATA_W-1:0] dout_en
);
  // R1
  enables_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n || !cs2) |=> (dout_en == '0));

  // R2
  lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_n == '1) |=> (dout_en == '0));

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs1_n && cs2 && !we_n) |=> (dout_en == '0));

  // R6
  output_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs1_n && cs2 && we_n && oe_n) |=> (dout_en == '0));

  // R5
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout & ~dout_en) == '0));

  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dout_en) && !cs1_n && cs2 && we_n && !oe_n
     && $stable(addr) && $stable(lane_n)) |=> $stable(dout));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R5
    lane_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_en[g*LANE_W +: LANE_W] == '0) || (dout_en[g*LANE_W +: LANE_W] == '1));
  end
endmodule

bind sram_bytelane sram_bytelane_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n),
  .oe_n(oe_n), .lane_n(lane_n), .addr(addr), .dout(dout), .dout_en(dout_en)
);

// File: tb/sram_bytelane_bench.sv
module sram_bytelane_bench;
  localparam int AW = 10, DEPTH = 64, FULL = 4, PAGE = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs1_n, cs2, we_n, oe_n;
  logic [1:0]  lane_n;
  logic [AW-1:0] addr;
  logic [15:0] din, dout, dout_en;
  logic [15:0] model [DEPTH];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_bytelane #(.ADDR_W(AW), .DEPTH(DEPTH), .FULL_LAT(FULL), .PAGE_LAT(PAGE))
  u_sram_bytelane (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n),
    .oe_n(oe_n), .lane_n(lane_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0301) ^ 16'h5AC3;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] ln);
    return {{8{~ln[1]}}, {8{~ln[0]}}};
  endfunction

  task automatic go_idle();
    cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; lane_n = 2'b00;
    @(negedge clk);
    check(dout_en == 16'h0, "R6 idle", dout_en, 16'h0);
  endtask

  // write one word; R3 output stays released, R4 lane update in the model
  task automatic wr(input int a, input logic [15:0] d, input logic [1:0] ln,
                    input logic oe);
    cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b0; oe_n = oe; lane_n = ln;
    addr = AW'(a); din = d;
    @(negedge clk);
    check(dout_en == 16'h0, "R3 write drives bus", dout_en, 16'h0);
    if (!ln[0]) model[a % DEPTH][7:0]  = d[7:0];
    if (!ln[1]) model[a % DEPTH][15:8] = d[15:8];
  endtask

  // read with an expected latency counted in sampling edges
  task automatic rd(input int a, input logic [1:0] ln, input int lat,
                    input string req);
    logic [15:0] m;
    cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b0; lane_n = ln;
    addr = AW'(a);
    m = lane_mask(ln);
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      if (i < lat) check(dout_en == 16'h0, {req, " early"}, dout_en, 16'h0);
      else begin
        check(dout_en == m, {req, " enable"}, dout_en, m);
        check(dout == (model[a % DEPTH] & m), {req, " data"}, dout,
              model[a % DEPTH] & m);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cs1_n = 1'b1; cs2 = 1'b0; we_n = 1'b1; oe_n = 1'b1; lane_n = 2'b11;
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    check(dout_en == 16'h0, "R10 in reset", dout_en, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout_en == 16'h0, "R10 after reset", dout_en, 16'h0);

    // full-word fill, output enable toggled during writes (R3)
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a), 2'b00, a[0]);

    // blocked writes and reads in standby and deselect (R1, R2)
    for (int a = 0; a < 8; a++) begin
      addr = AW'(a); din = 16'h0000; we_n = 1'b0; oe_n = 1'b1;
      cs1_n = 1'b1; cs2 = 1'b1; lane_n = 2'b00;
      @(negedge clk);
      check(dout_en == 16'h0, "R1 cs1 high", dout_en, 16'h0);
      cs1_n = 1'b0; cs2 = 1'b0;
      @(negedge clk);
      check(dout_en == 16'h0, "R1 cs2 low", dout_en, 16'h0);
      cs2 = 1'b1; lane_n = 2'b11;
      @(negedge clk);
      check(dout_en == 16'h0, "R2 lanes off", dout_en, 16'h0);
      we_n = 1'b1; oe_n = 1'b0; cs1_n = 1'b1; lane_n = 2'b00;
      repeat (FULL + 1) @(negedge clk);
      check(dout_en == 16'h0, "R1 read in standby", dout_en, 16'h0);
      cs1_n = 1'b0; lane_n = 2'b11;
      repeat (FULL + 1) @(negedge clk);
      check(dout_en == 16'h0, "R2 read deselected", dout_en, 16'h0);
    end

    // partial writes (R4)
    for (int a = 0; a < 16; a++) wr(a, ~pat(a + 7), 2'b10, 1'b0);
    for (int a = 16; a < 32; a++) wr(a, ~pat(a + 3), 2'b01, 1'b1);

    // aliasing via high address bits (R9)
    for (int a = 40; a < 48; a++) wr(a + DEPTH * ((a % 15) + 1), pat(a) ^ 16'hFFFF, 2'b00, 1'b0);

    // output off (R6)
    go_idle();
    go_idle();

    // fresh reads over every word, lanes cycling (R5, R7, R4, R9, R1, R2)
    for (int a = 0; a < DEPTH; a++) begin
      go_idle();
      rd(a, (a % 3 == 0) ? 2'b00 : ((a % 3 == 1) ? 2'b10 : 2'b01), FULL, "R7 fresh read");
    end

    // in-page walk (R8), then page change and lane change (R7)
    go_idle();
    rd(32, 2'b00, FULL, "R7 page open");
    for (int w = 1; w < 16; w++) rd(32 + w, 2'b00, PAGE, "R8 in-page");
    rd(48, 2'b00, FULL, "R7 page change");
    rd(48, 2'b01, FULL, "R7 lane change");
    repeat (3) begin
      @(negedge clk);
      check(dout == (model[48] & 16'hFF00), "R5 held read", dout, model[48] & 16'hFF00);
    end
    rd(49, 2'b01, PAGE, "R8 in-page after hold");

    // a write straight out of a read releases the bus (R3)
    wr(5, 16'h1234, 2'b00, 1'b0);
    go_idle();
    rd(5, 2'b00, FULL, "R4 full-word overwrite");

    finish_run();
  end
endmodule